// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a small data cache placed between a processor request port and a slower main-memory port. Each processor address is a word address that the cache splits into a tag, a set index and a word offset. All ways of the selected set are compared at once; a hit is answered combinationally in the cycle the request is presented, and a processor write that hits changes only the cached copy and marks the line dirty.

On a miss the cache picks a victim in the set, using an empty way if one exists and otherwise the way that was filled earliest. A dirty victim is first written to memory as a whole line, then the requested line is read in, and the request finishes one cycle after the refill is acknowledged. A write miss allocates the line and merges the write into it. The processor holds its request stable until it sees ready; the memory side holds its request stable until it sees a one-cycle acknowledge.

Top module: `wb_cache`

## Requirements
- R1: The word address is split with the offset in bits [1:0], the set index in bits [3:2] and the tag in the bits above (defaults: 4 sets, 4 words per line). Addresses differing only in offset share one line; the same tag in another set is a separate line.
- R2: A read whose tag matches a valid way of the selected set raises cpu_ready in the same cycle as the request, with the addressed word on cpu_rdata and no memory request.
- R3: A write that hits updates only the cached word and marks the line dirty; no memory transaction occurs for it.
- R4: A read miss issues one line read (mem_we low) at line address {tag, index}; cpu_ready stays low until the cycle after the refill acknowledge, when the word from the new line is returned.
- R5: When the selected set still has an invalid way, a miss fills the lowest-numbered invalid way and evicts no valid line.
- R6: In a full set the victim is the way whose fill is oldest (first-in-first-out per set).
- R7: A dirty victim is written to memory (mem_we high, line address {victim tag, index}, current line contents) before the refill read; a clean victim causes no memory write.
- R8: A write miss refills the line, then merges the write word and marks the line dirty, completing the cycle after the refill acknowledge.
- R9: mem_req, mem_we and mem_addr stay stable from the rise of mem_req until the cycle mem_ack is high.
- R10: Reset clears every valid and dirty bit and every set's replacement pointer: outputs are idle and the first access to any address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_ready |
| cpu_ready | output | 1 | Request completes this cycle |
| mem_req | output | 1 | Memory line transfer request |
| mem_we | output | 1 | 1 = line write-back, 0 = line refill |
| mem_addr | output | ADDR_W-OFF_W | Line address {tag, index} |
| mem_wline | output | LINE_WORDS*DATA_W | Line being written back, word 0 in the low bits |
| mem_rline | input | LINE_WORDS*DATA_W | Refill line, sampled with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the memory transfer |

## Verification
Directed sequences first separate the hit path from the miss path: repeated offsets within one line must hit, while the same tag in another set must miss. A set is then filled through its empty way, pushed past capacity so that the oldest line (made dirty) is evicted with a write-back, and refilled so that a clean line is evicted silently, which tells first-in-first-out apart from least-recently-used and from fixed-way choices. Write misses are checked by reading the merged word back. A long pseudo-random stream over a few tags per set then compares ready timing, read data and every memory transfer against a behavioural model on each clock.

// File: rtl/wb_cache.sv
module wb_cache #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int WAYS       = 2,
  parameter int SETS       = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [DATA_W-1:0]            cpu_wdata,
  output logic [DATA_W-1:0]            cpu_rdata,
  output logic                         cpu_ready,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0] mem_addr,
  output logic [LINE_WORDS*DATA_W-1:0] mem_wline,
  input  logic [LINE_WORDS*DATA_W-1:0] mem_rline,
  input  logic                         mem_ack
);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int LINE_W = LINE_WORDS * DATA_W;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL, S_RESP} st_t;
  st_t st_q;

  logic [LINE_W-1:0] line_q  [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [WAYS-1:0]   vld_q   [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [WAY_W-1:0]  fifo_q  [SETS];
  logic [WAY_W-1:0]  vict_q;
  logic              use_fifo_q;

  wire [TAG_W-1:0] tag = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] idx = cpu_addr[OFF_W +: IDX_W];
  wire [OFF_W-1:0] off = cpu_addr[OFF_W-1:0];

  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way, free_way, vict_way;
  logic             hit, has_free;

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld_q[idx][w] && (tag_q[idx][w] == tag);
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_q[idx][w]) free_way = WAY_W'(w);
  end

  assign hit      = |hit_vec;
  assign has_free = ~&vld_q[idx];
  assign vict_way = has_free ? free_way : fifo_q[idx];

  wire [WAY_W-1:0]  acc_way  = (st_q == S_RESP) ? vict_q : hit_way;
  wire [LINE_W-1:0] acc_line = line_q[idx][acc_way];
  wire              do_write;

  assign cpu_rdata = acc_line[off*DATA_W +: DATA_W];
  assign cpu_ready = (st_q == S_IDLE && cpu_req && hit) || st_q == S_RESP;
  assign do_write  = cpu_ready && cpu_req && cpu_we;
  assign mem_req   = (st_q == S_WB) || (st_q == S_FILL);
  assign mem_we    = (st_q == S_WB);
  assign mem_addr  = (st_q == S_WB) ? {tag_q[idx][vict_q], idx} : {tag, idx};
  assign mem_wline = line_q[idx][vict_q];

  always_ff @(posedge clk) begin
    if (st_q == S_FILL && mem_ack) begin
      line_q[idx][vict_q] <= mem_rline;
      tag_q[idx][vict_q]  <= tag;
    end
    if (do_write)
      line_q[idx][acc_way][off*DATA_W +: DATA_W] <= cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      vict_q     <= '0;
      use_fifo_q <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]   <= '0;
        dirty_q[s] <= '0;
        fifo_q[s]  <= '0;
      end
    end else begin
      case (st_q)
        S_IDLE:
          if (cpu_req && !hit) begin
            vict_q     <= vict_way;
            use_fifo_q <= !has_free;
            st_q <= (vld_q[idx][vict_way] && dirty_q[idx][vict_way]) ? S_WB : S_FILL;
          end
        S_WB:
          if (mem_ack) st_q <= S_FILL;
        S_FILL:
          if (mem_ack) begin
            vld_q[idx][vict_q]   <= 1'b1;
            dirty_q[idx][vict_q] <= 1'b0;
            if (use_fifo_q) fifo_q[idx] <= fifo_q[idx] + WAY_W'(1);
            st_q <= S_RESP;
          end
        default:
          st_q <= S_IDLE;
      endcase
      if (do_write) dirty_q[idx][acc_way] <= 1'b1;
    end
  end

  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> $countones(hit_vec) <= 1);

  p_free_way_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && cpu_req && !hit && has_free) |=> (mem_req && !mem_we));

  p_wb_victim_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WB) |-> (vld_q[idx][vict_q] && dirty_q[idx][vict_q]));

  p_wb_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

  p_fill_then_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> cpu_ready);

  p_hold_mem_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));
endmodule

// File: tb/wb_cache_tb_top.sv
module wb_cache_tb_top;
  localparam int AW = 16, DW = 32, NW = 2, NS = 4, LW = 4, LAT = 2;
  localparam int LINE_W = LW * DW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0, cpu_ready, mem_req, mem_we, mem_ack = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic [AW-3:0] mem_addr;
  logic [LINE_W-1:0] mem_wline, mem_rline = '0;

  int checks = 0, fails = 0, last_cycles = 0;
  bit done = 0;

  int          m_tag   [NS][NW];
  bit          m_val   [NS][NW];
  bit          m_dirty [NS][NW];
  logic [31:0] m_data  [NS][NW][LW];
  int          m_fifo  [NS];
  logic [31:0] memw [int];

  always #4 clk = ~clk;

  wb_cache #(.ADDR_W(AW), .DATA_W(DW), .WAYS(NW), .SETS(NS), .LINE_WORDS(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wline(mem_wline),
    .mem_rline(mem_rline), .mem_ack(mem_ack));

  function automatic logic [31:0] mem_rd(int wa);
    if (memw.exists(wa)) return memw[wa];
    return 32'h5A00_0000 ^ (wa * 32'h0001_0301);
  endfunction

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [AW-1:0] addr, input logic [DW-1:0] wd);
    int tg, st, of, way, vw, exp_cycles, cycles, wait_c, nwb, nrd;
    bit miss, exp_wb, full;
    logic [AW-3:0] wb_addr, rd_addr, first_addr;
    logic [LINE_W-1:0] wb_line, rline;
    logic [31:0] exp_rd;
    string tagr;
    tg = int'(addr[AW-1:4]); st = int'(addr[3:2]); of = int'(addr[1:0]);
    way = -1;
    for (int w = 0; w < NW; w++) if (m_val[st][w] && m_tag[st][w] == tg) way = w;
    miss = (way < 0); exp_wb = 0; wb_line = '0; wb_addr = '0;
    rd_addr = {addr[AW-1:4], addr[3:2]};
    if (miss) begin
      vw = -1;
      for (int w = NW - 1; w >= 0; w--) if (!m_val[st][w]) vw = w;
      full = (vw < 0);
      if (full) begin vw = m_fifo[st]; m_fifo[st] = (m_fifo[st] + 1) % NW; end
      exp_wb = m_val[st][vw] && m_dirty[st][vw];
      wb_addr = {m_tag[st][vw][AW-5:0], 2'(st)};
      for (int i = 0; i < LW; i++) wb_line[i*DW +: DW] = m_data[st][vw][i];
      if (exp_wb)
        for (int i = 0; i < LW; i++) memw[int'(wb_addr) * LW + i] = m_data[st][vw][i];
      for (int i = 0; i < LW; i++) m_data[st][vw][i] = mem_rd(int'(rd_addr) * LW + i);
      m_tag[st][vw] = tg; m_val[st][vw] = 1; m_dirty[st][vw] = 0;
      way = vw;
    end
    if (we) begin m_data[st][way][of] = wd; m_dirty[st][way] = 1; end
    exp_rd = m_data[st][way][of];
    exp_cycles = miss ? 2 + LAT * (exp_wb ? 2 : 1) : 1;
    tagr = miss ? (we ? "R8" : "R4") : (we ? "R3" : "R2");

    @(posedge clk); #1;
    cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    cycles = 0; wait_c = 0; nwb = 0; nrd = 0; first_addr = '0;
    forever begin
      @(negedge clk);
      cycles++;
      chk(cpu_ready == (cycles == exp_cycles), tagr, "ready timing",
          LINE_W'(cpu_ready), LINE_W'(cycles == exp_cycles));
      if (cpu_ready || cycles > exp_cycles + 4) break;
      mem_ack = 0;
      if (mem_req) begin
        wait_c++;
        if (wait_c == 1) first_addr = mem_addr;
        if (wait_c == LAT) begin
          wait_c = 0; mem_ack = 1;
          chk(mem_addr == first_addr, "R9", "held mem address", LINE_W'(mem_addr), LINE_W'(first_addr));
          if (mem_we) begin
            nwb++;
            chk(mem_addr == wb_addr, "R7", "write-back address", LINE_W'(mem_addr), LINE_W'(wb_addr));
            chk(mem_wline == wb_line, "R7", "write-back line", mem_wline, wb_line);
          end else begin
            nrd++;
            chk(mem_addr == rd_addr, "R4", "refill address", LINE_W'(mem_addr), LINE_W'(rd_addr));
            for (int i = 0; i < LW; i++) rline[i*DW +: DW] = mem_rd(int'(mem_addr) * LW + i);
            mem_rline = rline;
          end
        end
      end
    end
    if (!we) chk(cpu_rdata == exp_rd, tagr, "read data", LINE_W'(cpu_rdata), LINE_W'(exp_rd));
    chk(nwb == int'(exp_wb), exp_wb ? "R7" : (miss ? "R7" : "R3"), "write-back count",
        LINE_W'(nwb), LINE_W'(exp_wb));
    chk(nrd == int'(miss), miss ? "R4" : "R2", "refill count", LINE_W'(nrd), LINE_W'(miss));
    last_cycles = cycles;
    @(posedge clk); #1;
    cpu_req = 0; mem_ack = 0;
  endtask

  function automatic logic [AW-1:0] mk(int tg, int st, int of);
    return {12'(tg), 2'(st), 2'(of)};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int s = 0; s < NS; s++) begin
      m_fifo[s] = 0;
      for (int w = 0; w < NW; w++) begin m_val[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = 0; end
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!cpu_ready && !mem_req, "R10", "idle after reset", LINE_W'({cpu_ready, mem_req}), '0);

    access(0, mk(1, 0, 1), 0);
    chk(last_cycles == 2 + LAT, "R10", "first access misses", LINE_W'(last_cycles), LINE_W'(2 + LAT));
    access(0, mk(1, 0, 3), 0);
    chk(last_cycles == 1, "R1", "same line other offset hits", LINE_W'(last_cycles), 1);
    access(0, mk(1, 1, 3), 0);
    chk(last_cycles == 2 + LAT, "R1", "same tag other set misses", LINE_W'(last_cycles), LINE_W'(2 + LAT));
    access(1, mk(1, 0, 2), 32'hCAFE_0001);
    access(0, mk(1, 0, 2), 0);
    access(0, mk(2, 0, 0), 0);
    access(0, mk(1, 0, 0), 0);
    chk(last_cycles == 1, "R5", "empty way used, old line kept", LINE_W'(last_cycles), 1);
    access(0, mk(3, 0, 1), 0);
    chk(last_cycles == 2 + 2 * LAT, "R6", "oldest dirty way evicted", LINE_W'(last_cycles), LINE_W'(2 + 2 * LAT));
    access(0, mk(2, 0, 0), 0);
    chk(last_cycles == 1, "R6", "younger line survives", LINE_W'(last_cycles), 1);
    access(0, mk(1, 0, 2), 0);
    chk(last_cycles == 2 + LAT, "R6", "clean eviction, no write-back", LINE_W'(last_cycles), LINE_W'(2 + LAT));
    access(1, mk(5, 2, 1), 32'h1234_5678);
    chk(last_cycles == 2 + LAT, "R8", "write miss latency", LINE_W'(last_cycles), LINE_W'(2 + LAT));
    access(0, mk(5, 2, 1), 0);
    access(0, mk(5, 2, 0), 0);

    seed = 32'h1F2E3D;
    for (int n = 0; n < 400; n++) begin
      seed = seed * 1103515245 + 12345;
      access(seed[16], mk(int'(seed[19:17]) % 5, int'(seed[21:20]), int'(seed[23:22])), seed ^ n);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule